// File: doc/BRIEF.md
# Output Source Selector for a Register-Backed Configuration Switch

This block drives a word of open-drain output lines from one of five sources: four stored configuration words, or an external input word taken from pins. The choice belongs either to a select pin or to an output-source command that arrives through the serial interface. A command takes ownership away from the pin until a release command hands it back.

Command codes take effect in the cycle in which `cmd_valid` is sampled high. Codes F8h to FBh force stored word 0 to 3, with bits [1:0] of the code giving the index. FCh forces the external word. FEh returns control to the pin and keeps the last index that was forced. Every other code is ignored.

The block does not decode the serial protocol and does not hold the stored words. The pull-ups on the external inputs and the select pin belong to the pad ring, so an undriven pin reaches this block as a 1.

Top module: `outsel_mux`

## Requirements
- R1: While reset is asserted, every line is released (`line_pull` all 0). After reset the block is in pin mode with index 0, whatever was forced before reset.
- R2: A valid command F8h, F9h, FAh or FBh selects stored word 0, 1, 2 or 3 (code bits [1:0]), whatever the level of `sel_pin`.
- R3: A valid command FCh selects `ext_word`, whatever the level of `sel_pin`.
- R4: A valid command FEh returns control to the pin. In pin mode, `sel_pin`=0 selects the stored word at the current index and `sel_pin`=1 selects `ext_word`.
- R5: A valid command with any other code changes neither the mode nor the index.
- R6: The outputs are open drain. `line_pull[i]`=1 pulls line i low for a 0 data bit, and `line_pull[i]`=0 releases it for a 1 bit.
- R7: The output is registered. A change of command, select pin, external word or the selected stored word appears at the clock edge that samples it.
- R8: While `cmd_valid` is low, `cmd_code` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_word | input | NREG*W (24) | Stored words; word k is bits [k*W +: W] |
| ext_word | input | W (6) | External input word |
| sel_pin | input | 1 | Pin select: 0 selects a stored word, 1 selects the external word |
| cmd_valid | input | 1 | Strobe that marks an accepted command byte |
| cmd_code | input | 8 | Command byte |
| line_pull | output | W (6) | Open-drain pull-down enable for each line |

## Verification
A wrong mode or a wrong index shows on `line_pull` one clock after the command or pin change that exposed it. In that cycle the lines carry another word's pattern, or a word that should be overridden. A lost index appears only when control goes back to the pin with `sel_pin` low, so the directed cases force a nonzero index, pass through the external source, and then release. A reset that keeps stale state shows as a stored word other than word 0 on the first cycle after reset.

// File: rtl/outsel_mux.sv
module outsel_mux #(
  parameter int W = 6,
  parameter int NREG = 4,
  parameter int CW = 8,
  parameter logic [CW-1:0] FORCE_BASE = 8'hF8,
  parameter logic [CW-1:0] EXT_CODE = 8'hFC,
  parameter logic [CW-1:0] PIN_CODE = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG*W-1:0] bank_word,
  input  logic [W-1:0]      ext_word,
  input  logic              sel_pin,
  input  logic              cmd_valid,
  input  logic [CW-1:0]     cmd_code,
  output logic [W-1:0]      line_pull
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [1:0] {SRC_PIN, SRC_REG, SRC_EXT} src_t;

  src_t          mode, mode_n;
  logic [IW-1:0] idx, idx_n;
  logic [W-1:0]  word_q, word_n;

  function automatic logic [W-1:0] slot(input logic [NREG*W-1:0] b, input logic [IW-1:0] i);
    return b[32'(i)*W +: W];
  endfunction

  wire is_force = cmd_valid && (cmd_code[CW-1:IW] == FORCE_BASE[CW-1:IW]);
  wire is_ext   = cmd_valid && (cmd_code == EXT_CODE);
  wire is_pin   = cmd_valid && (cmd_code == PIN_CODE);

  always_comb begin
    mode_n = mode;
    idx_n  = idx;
    if (is_force) begin
      mode_n = SRC_REG;
      idx_n  = cmd_code[IW-1:0];
    end else if (is_ext) begin
      mode_n = SRC_EXT;
    end else if (is_pin) begin
      mode_n = SRC_PIN;
    end
    case (mode_n)
      SRC_REG: word_n = slot(bank_word, idx_n);
      SRC_EXT: word_n = ext_word;
      default: word_n = sel_pin ? ext_word : slot(bank_word, idx_n);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= SRC_PIN;
      idx    <= '0;
      word_q <= '1;
    end else begin
      mode   <= mode_n;
      idx    <= idx_n;
      word_q <= word_n;
    end
  end

  assign line_pull = ~word_q;

  assert_force_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[CW-1:IW] == FORCE_BASE[CW-1:IW])
      |=> line_pull == ~slot($past(bank_word), $past(cmd_code[IW-1:0])));

  assert_force_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == EXT_CODE) |=> line_pull == ~$past(ext_word));

  assert_pin_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == PIN_CODE && sel_pin) |=> line_pull == ~$past(ext_word));

  assert_reserved_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[CW-1:IW] != FORCE_BASE[CW-1:IW] && cmd_code != EXT_CODE
     && cmd_code != PIN_CODE) |=> ($stable(mode) && $stable(idx)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(mode) && $stable(idx)));
endmodule

// File: tb/outsel_mux_test.sv
module outsel_mux_test;
  localparam int W = 6;
  localparam int NREG = 4;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [NREG*W-1:0] bank_word = '0;
  logic [W-1:0]      ext_word = '0;
  logic              sel_pin = 0;
  logic              cmd_valid = 0;
  logic [7:0]        cmd_code = '0;
  logic [W-1:0]      line_pull;

  int vectors = 0;
  int errors = 0;
  int m_mode = 0;
  int m_idx = 0;

  outsel_mux uut (.clk(clk), .rst_n(rst_n), .bank_word(bank_word), .ext_word(ext_word),
                  .sel_pin(sel_pin), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
                  .line_pull(line_pull));

  always #10 clk = ~clk;

  function automatic void apply_cmd(input logic v, input logic [7:0] c);
    if (!v) return;
    if (c >= 8'hF8 && c <= 8'hFB) begin m_mode = 1; m_idx = int'(c - 8'hF8); end
    else if (c == 8'hFC) m_mode = 2;
    else if (c == 8'hFE) m_mode = 0;
  endfunction

  function automatic logic [W-1:0] exp_pull();
    logic [W-1:0] w;
    if (m_mode == 2 || (m_mode == 0 && sel_pin)) w = ext_word;
    else w = bank_word[m_idx*W +: W];
    return ~w;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    vectors++;
    if (line_pull !== exp) begin
      errors++;
      $display("FAIL %s: line_pull=%b expected=%b", tag, line_pull, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [7:0] c);
    logic [W-1:0] e;
    cmd_valid = v;
    cmd_code = c;
    apply_cmd(v, c);
    e = exp_pull();
    @(negedge clk);
    check(tag, e);
  endtask

  task automatic do_reset();
    rst_n = 0;
    cmd_valid = 0;
    m_mode = 0;
    m_idx = 0;
    @(negedge clk);
    check("R1 lines released in reset", '0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    bank_word = {6'h2A, 6'h15, 6'h0F, 6'h31};
    ext_word = 6'h27;
    do_reset();
    step("R1 pin mode index 0", 0, 8'h00);
    sel_pin = 1;
    step("R4 pin select external", 0, 8'h00);
    step("R2 force word 2 over pin", 1, 8'hFA);
    step("R8 strobe low ignored", 0, 8'hFC);
    step("R5 reserved code ignored", 1, 8'hFD);
    step("R5 reserved code FF ignored", 1, 8'hFF);
    bank_word[2*W +: W] = 6'h3C;
    step("R7 selected word follows", 0, 8'h00);
    sel_pin = 0;
    ext_word = 6'h00;
    step("R3 force external all zero R6", 1, 8'hFC);
    ext_word = 6'h3F;
    step("R6 all ones released", 0, 8'h00);
    step("R4 release keeps index 2", 1, 8'hFE);
    step("R2 force word 3", 1, 8'hFB);
    sel_pin = 1;
    step("R2 pin ignored when forced", 0, 8'h00);
    step("R2 force word 1", 1, 8'hF9);
    do_reset();
    sel_pin = 0;
    step("R1 reset restores word 0", 0, 8'h00);

    for (int n = 0; n < 400; n++) begin
      logic v;
      logic [7:0] c;
      int r;
      bank_word = {$urandom, $urandom};
      if ($urandom % 3 == 0) ext_word = W'($urandom);
      if ($urandom % 4 == 0) sel_pin = ~sel_pin;
      v = ($urandom % 3 == 0);
      r = $urandom % 8;
      if (r < 4) c = 8'hF8 + 8'(r);
      else if (r == 4) c = 8'hFC;
      else if (r == 5) c = 8'hFE;
      else c = 8'($urandom);
      step("R7 random mix", v, c);
    end
    cmd_valid = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule